// File: doc/BRIEF.md
# UART Bus Register Front End

This block sits between a pipelined 32-bit memory bus slave port and the separate serial transmitter and receiver cores of a UART. It holds four word registers: a read-only status word, a read/write control word, a read-only receive data word and a write-only transmit data word. The control word goes out to both cores as configuration: baud divider, character length, parity enable and stop-bit count.

Some accesses have side effects. Reading the receive data word empties it. Reading the status word clears the sticky error flags once it has returned them. Writing the transmit word starts a frame if the transmitter is idle. Any write that changes the control word sends a one-cycle abort pulse to both cores. The receiver core reports each finished character with a one-cycle strobe, the character and its parity and framing error bits.

Top module: `uart_bus_regs`

## Requirements
- R1: While `rst` is high and after it falls, every register reads as zero, the configuration outputs are zero, and `busAck`, `txStart` and `cancelXfer` are low.
- R2: A transfer is accepted in any cycle with `busCyc` and `busStb` high, because `busStall` stays low. `busAck` is high in exactly the following cycle, and read data is valid on `busDatOut` in that same cycle.
- R3: The control word at offset 0x4 is written only in the bytes whose `busSel` bit is set. Only bits [19:0] are stored and the rest read as zero. The fields are: bits [15:0] clock divider, bits [17:16] character length (0 = 5 bits up to 3 = 8 bits), bit 18 parity enable, bit 19 two stop bits. They drive `cfgClkDiv`, `cfgDataSize`, `cfgParityEn` and `cfgTwoStop`.
- R4: An access to an offset that is not 0x0, 0x4, 0x8 or 0xC is still acknowledged. A read there returns zero, and a write there changes no register.
- R5: A `rxDone` strobe loads `rxByte` into bits [7:0] of the receive word at offset 0x8 and sets RXNE. The status layout is: bit 0 RXNE, bit 1 transmitter busy (the live `txBusy` input), bit 2 parity error, bit 3 framing error, bit 4 overrun. All other bits are zero.
- R6: A read of the receive word returns the character, then clears the word to zero and clears RXNE.
- R7: A `rxDone` strobe sets the parity error flag when `rxParityErr` is high and the framing error flag when `rxFrameErr` is high. These flags stay set until a status read returns them, and that read clears them.
- R8: A `rxDone` strobe that arrives while RXNE is already set sets the overrun flag, and the new character replaces the old one.
- R9: A write to offset 0xC with `busSel[0]` set while `txBusy` is low drives `txStart` high for exactly the cycle of its acknowledge, with bits [7:0] on `txByte`. A write while `txBusy` is high, or with `busSel[0]` clear, starts nothing.
- R10: A control write that changes the stored value drives `cancelXfer` high for exactly the acknowledge cycle. A control write that leaves the value unchanged does not.
- R11: The transmit word is write-only. Reading offset 0xC returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 5 | Byte offset of the access |
| busDatIn | input | 32 | Write data |
| busDatOut | output | 32 | Read data, valid with busAck |
| busSel | input | 4 | Byte lane selects |
| busWe | input | 1 | High for write, low for read |
| busStb | input | 1 | Transfer strobe |
| busCyc | input | 1 | Bus cycle in progress |
| busAck | output | 1 | Transfer acknowledge |
| busStall | output | 1 | Stall, always low |
| txBusy | input | 1 | Transmitter is sending a frame |
| txStart | output | 1 | One-cycle start request to the transmitter |
| txByte | output | 8 | Character to transmit |
| rxDone | input | 1 | Receiver finished a character |
| rxByte | input | 8 | Received character |
| rxParityErr | input | 1 | Parity mismatch on that character |
| rxFrameErr | input | 1 | Stop bit was low on that character |
| cancelXfer | output | 1 | Abort pulse to both cores |
| cfgClkDiv | output | 16 | Baud clock divider |
| cfgDataSize | output | 2 | Character length code |
| cfgParityEn | output | 1 | Parity enable |
| cfgTwoStop | output | 1 | Two stop bits |

## Verification
The hardest cases to reach are the ones where receiver events and register reads interact. An overrun needs two completion strobes with no receive-data read between them. An error flag needs a status read to observe it and then a second read to show that the first read cleared it. The bench drives the receiver-side inputs directly as a model core, so it can place these strobes between bus transactions in any order. It sweeps all sixteen byte-select patterns across control writes, checking both the merge and the abort pulse, and it tries every unmapped offset with a write followed by a read-back.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  // Per-access strobes from bus decode to the register datapath
  typedef struct packed {
    logic rdStatus;
    logic rdCtrl;
    logic rdRx;
    logic wrCtrl;
    logic wrTx;
  } regStrobes_t;

  localparam int unsigned CLKDIV_W = 16;
  localparam int unsigned CTRL_W   = CLKDIV_W + 4;
  localparam int unsigned CHAR_W   = 8;
endpackage

// File: rtl/uart_regs_ctrl.sv
module uart_regs_ctrl
  import uart_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busStb,
  input  logic              busCyc,
  output logic              busAck,
  output regStrobes_t       strobes
);
  localparam logic [1:0] IDX_STATUS = 2'd0;
  localparam logic [1:0] IDX_CTRL   = 2'd1;
  localparam logic [1:0] IDX_RX     = 2'd2;
  localparam logic [1:0] IDX_TX     = 2'd3;

  logic accept;
  logic mapped;
  logic [1:0] idx;

  assign accept = busCyc && busStb;
  assign mapped = ((busAddr >> 4) == '0) && (busAddr[1:0] == 2'b00);
  assign idx    = busAddr[3:2];

  always_comb begin
    strobes = '0;
    if (accept && mapped) begin
      strobes.rdStatus = !busWe && (idx == IDX_STATUS);
      strobes.rdCtrl   = !busWe && (idx == IDX_CTRL);
      strobes.rdRx     = !busWe && (idx == IDX_RX);
      strobes.wrCtrl   =  busWe && (idx == IDX_CTRL);
      strobes.wrTx     =  busWe && (idx == IDX_TX);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) busAck <= 1'b0;
    else     busAck <= accept;
  end

  p_ack_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> busAck);
  p_ack_needs_accept_r2: assert property (@(posedge clk) disable iff (rst)
    busAck |-> $past(accept));
  p_single_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes));
endmodule

// File: rtl/uart_regs_data.sv
module uart_regs_data
  import uart_regs_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  regStrobes_t         strobes,
  input  logic [DATA_W-1:0]   busDatIn,
  input  logic [DATA_W/8-1:0] busSel,
  output logic [DATA_W-1:0]   busDatOut,
  input  logic                txBusy,
  output logic                txStart,
  output logic [CHAR_W-1:0]   txByte,
  input  logic                rxDone,
  input  logic [CHAR_W-1:0]   rxByte,
  input  logic                rxParityErr,
  input  logic                rxFrameErr,
  output logic                cancelXfer,
  output logic [CTRL_W-1:0]   ctrlWord
);
  localparam int unsigned LANES = DATA_W / 8;

  logic [CTRL_W-1:0] ctrlReg;
  logic [DATA_W-1:0] ctrlWide, ctrlMerged;
  logic [CTRL_W-1:0] ctrlNext;
  logic [CHAR_W-1:0] rxData;
  logic rxne, peFlag, feFlag, oeFlag;
  logic [DATA_W-1:0] statusWord, rdValue;

  assign ctrlWide = DATA_W'(ctrlReg);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign ctrlMerged[b*8 +: 8] = busSel[b] ? busDatIn[b*8 +: 8] : ctrlWide[b*8 +: 8];
  end
  assign ctrlNext = ctrlMerged[CTRL_W-1:0];
  assign ctrlWord = ctrlReg;

  assign statusWord = DATA_W'({oeFlag, feFlag, peFlag, txBusy, rxne});

  always_comb begin
    rdValue = '0;
    if (strobes.rdStatus) rdValue = statusWord;
    if (strobes.rdCtrl)   rdValue = ctrlWide;
    if (strobes.rdRx)     rdValue = DATA_W'(rxData);
  end

  // Control word and abort pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg    <= '0;
      cancelXfer <= 1'b0;
    end else begin
      cancelXfer <= strobes.wrCtrl && (ctrlNext != ctrlReg);
      if (strobes.wrCtrl) ctrlReg <= ctrlNext;
    end
  end

  // Transmit launch
  always_ff @(posedge clk) begin
    if (rst) begin
      txStart <= 1'b0;
      txByte  <= '0;
    end else begin
      txStart <= strobes.wrTx && busSel[0] && !txBusy;
      if (strobes.wrTx && busSel[0] && !txBusy) txByte <= busDatIn[CHAR_W-1:0];
    end
  end

  // Receive data and sticky flags; a new character wins over a clearing read
  always_ff @(posedge clk) begin
    if (rst) begin
      rxData <= '0;
      rxne   <= 1'b0;
      peFlag <= 1'b0;
      feFlag <= 1'b0;
      oeFlag <= 1'b0;
    end else begin
      if (rxDone)            rxData <= rxByte;
      else if (strobes.rdRx) rxData <= '0;
      rxne   <= rxDone || (rxne && !strobes.rdRx);
      peFlag <= (peFlag && !strobes.rdStatus) || (rxDone && rxParityErr);
      feFlag <= (feFlag && !strobes.rdStatus) || (rxDone && rxFrameErr);
      oeFlag <= (oeFlag && !strobes.rdStatus) || (rxDone && rxne && !strobes.rdRx);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) busDatOut <= '0;
    else     busDatOut <= rdValue;
  end

  p_rxne_set_r5: assert property (@(posedge clk) disable iff (rst)
    rxDone |=> rxne);
  p_rx_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (strobes.rdRx && !rxDone) |=> (!rxne && rxData == '0));
  p_status_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (strobes.rdStatus && !rxDone) |=> (!peFlag && !feFlag && !oeFlag));
  p_tx_idle_start_r9: assert property (@(posedge clk) disable iff (rst)
    txStart |-> !$past(txBusy));
  p_cancel_on_change_r10: assert property (@(posedge clk) disable iff (rst)
    cancelXfer |-> (ctrlReg != $past(ctrlReg)));
endmodule

// File: rtl/uart_bus_regs.sv
module uart_bus_regs
  import uart_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busDatIn,
  output logic [DATA_W-1:0]     busDatOut,
  input  logic [DATA_W/8-1:0]   busSel,
  input  logic                  busWe,
  input  logic                  busStb,
  input  logic                  busCyc,
  output logic                  busAck,
  output logic                  busStall,
  input  logic                  txBusy,
  output logic                  txStart,
  output logic [CHAR_W-1:0]     txByte,
  input  logic                  rxDone,
  input  logic [CHAR_W-1:0]     rxByte,
  input  logic                  rxParityErr,
  input  logic                  rxFrameErr,
  output logic                  cancelXfer,
  output logic [CLKDIV_W-1:0]   cfgClkDiv,
  output logic [1:0]            cfgDataSize,
  output logic                  cfgParityEn,
  output logic                  cfgTwoStop
);
  regStrobes_t strobes;
  logic [CTRL_W-1:0] ctrlWord;

  assign busStall    = 1'b0;
  assign cfgClkDiv   = ctrlWord[CLKDIV_W-1:0];
  assign cfgDataSize = ctrlWord[CLKDIV_W+1:CLKDIV_W];
  assign cfgParityEn = ctrlWord[CLKDIV_W+2];
  assign cfgTwoStop  = ctrlWord[CLKDIV_W+3];

  uart_regs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe),
    .busStb(busStb), .busCyc(busCyc), .busAck(busAck), .strobes(strobes)
  );

  uart_regs_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .strobes(strobes), .busDatIn(busDatIn),
    .busSel(busSel), .busDatOut(busDatOut), .txBusy(txBusy),
    .txStart(txStart), .txByte(txByte), .rxDone(rxDone), .rxByte(rxByte),
    .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr),
    .cancelXfer(cancelXfer), .ctrlWord(ctrlWord)
  );
endmodule

// File: tb/tb_uart_bus_regs.sv
`timescale 1ns/100ps
module tb_uart_bus_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0]  busAddr = '0;
  logic [31:0] busDatIn = '0;
  logic [31:0] busDatOut;
  logic [3:0]  busSel = '0;
  logic busWe = 1'b0, busStb = 1'b0, busCyc = 1'b0;
  logic busAck, busStall;
  logic txBusy = 1'b0;
  logic txStart;
  logic [7:0] txByte;
  logic rxDone = 1'b0;
  logic [7:0] rxByte = '0;
  logic rxParityErr = 1'b0, rxFrameErr = 1'b0;
  logic cancelXfer;
  logic [15:0] cfgClkDiv;
  logic [1:0]  cfgDataSize;
  logic cfgParityEn, cfgTwoStop;

  int total = 0;
  int bad = 0;
  logic [31:0] rdData;
  logic ackSeen, startSeen, cancelSeen;
  logic [19:0] ctrlExp;

  always #2.5 clk = ~clk;

  uart_bus_regs dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One transfer: drive at negedge, accepted at next posedge, sampled at the following negedge
  task automatic xfer(input logic we, input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    busCyc = 1'b1; busStb = 1'b1; busWe = we; busAddr = a; busDatIn = d; busSel = s;
    @(negedge clk);
    busCyc = 1'b0; busStb = 1'b0; busWe = 1'b0;
    ackSeen = busAck; rdData = busDatOut; startSeen = txStart; cancelSeen = cancelXfer;
  endtask

  task automatic rxEvent(input logic [7:0] b, input logic pe, input logic fe);
    @(negedge clk);
    rxDone = 1'b1; rxByte = b; rxParityErr = pe; rxFrameErr = fe;
    @(negedge clk);
    rxDone = 1'b0; rxParityErr = 1'b0; rxFrameErr = 1'b0;
  endtask

  function automatic logic [19:0] merge(input logic [19:0] old, input logic [31:0] d, input logic [3:0] s);
    logic [31:0] w;
    w = {12'b0, old};
    for (int b = 0; b < 4; b++) if (s[b]) w[b*8 +: 8] = d[b*8 +: 8];
    return w[19:0];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ack in reset", {31'b0, busAck}, 0);
    rst = 1'b0;
    chk("R1 cfg zero", {cfgClkDiv, cfgDataSize, cfgParityEn, cfgTwoStop, txStart, cancelXfer}, 0);
    for (int a = 0; a < 16; a += 4) begin
      xfer(1'b0, 5'(a), 0, 4'hF);
      chk("R1 reset read", rdData, 0);
      chk("R2 ack", {31'b0, ackSeen}, 1);
    end
    chk("R2 stall low", {31'b0, busStall}, 0);
    @(negedge clk);
    chk("R2 ack one cycle", {31'b0, busAck}, 0);

    // R3 / R10: byte-select sweep on control word
    ctrlExp = '0;
    for (int s = 0; s < 16; s++) begin
      logic [31:0] d;
      logic [19:0] nx;
      d = 32'hC3A5_1E00 ^ (32'(s) * 32'h0107_0B0D);
      nx = merge(ctrlExp, d, 4'(s));
      xfer(1'b1, 5'h4, d, 4'(s));
      chk("R10 cancel on change", {31'b0, cancelSeen}, {31'b0, nx != ctrlExp});
      ctrlExp = nx;
      xfer(1'b0, 5'h4, 0, 4'hF);
      chk("R3 ctrl readback", rdData, {12'b0, ctrlExp});
      chk("R3 cfg fields", {12'b0, cfgTwoStop, cfgParityEn, cfgDataSize, cfgClkDiv}, {12'b0, ctrlExp});
    end
    xfer(1'b1, 5'h4, {12'b0, ctrlExp}, 4'hF);
    chk("R10 no cancel same value", {31'b0, cancelSeen}, 0);
    @(negedge clk);
    chk("R10 cancel one cycle", {31'b0, cancelXfer}, 0);

    // R4: every unmapped offset
    for (int a = 0; a < 32; a++) begin
      if (a == 0 || a == 4 || a == 8 || a == 12) continue;
      xfer(1'b1, 5'(a), 32'hFFFF_FFFF, 4'hF);
      chk("R4 unmapped write ack", {31'b0, ackSeen}, 1);
      chk("R4 unmapped write no start", {30'b0, startSeen, cancelSeen}, 0);
      xfer(1'b0, 5'(a), 0, 4'hF);
      chk("R4 unmapped read zero", rdData, 0);
    end
    xfer(1'b0, 5'h4, 0, 4'hF);
    chk("R4 ctrl untouched", rdData, {12'b0, ctrlExp});
    xfer(1'b0, 5'h0, 0, 4'hF);
    chk("R4 status untouched", rdData, 0);

    // R5 / R6: receive sweep
    for (int b = 0; b < 256; b += 17) begin
      rxEvent(8'(b), 1'b0, 1'b0);
      xfer(1'b0, 5'h0, 0, 4'hF);
      chk("R5 rxne set", rdData, 32'h1);
      xfer(1'b0, 5'h8, 0, 4'hF);
      chk("R6 rx data", rdData, 32'(b));
      xfer(1'b0, 5'h8, 0, 4'hF);
      chk("R6 rx cleared", rdData, 0);
      xfer(1'b0, 5'h0, 0, 4'hF);
      chk("R6 rxne cleared", rdData, 0);
    end

    // R7: error flag combinations
    for (int e = 0; e < 4; e++) begin
      rxEvent(8'h3C, e[0], e[1]);
      xfer(1'b0, 5'h0, 0, 4'hF);
      chk("R7 flags reported", rdData, 32'h1 | (32'(e[0]) << 2) | (32'(e[1]) << 3));
      xfer(1'b0, 5'h0, 0, 4'hF);
      chk("R7 flags cleared by read", rdData, 32'h1);
      xfer(1'b0, 5'h8, 0, 4'hF);
    end

    // R8: overrun
    rxEvent(8'h11, 1'b0, 1'b0);
    rxEvent(8'h22, 1'b0, 1'b0);
    xfer(1'b0, 5'h0, 0, 4'hF);
    chk("R8 overrun flag", rdData, 32'h11);
    xfer(1'b0, 5'h8, 0, 4'hF);
    chk("R8 newest kept", rdData, 32'h22);
    xfer(1'b0, 5'h0, 0, 4'hF);
    chk("R8 overrun cleared", rdData, 0);

    // R9 / R11: transmit
    xfer(1'b1, 5'hC, 32'hDEAD_BE5A, 4'h1);
    chk("R9 start pulse", {31'b0, startSeen}, 1);
    chk("R9 tx byte", {24'b0, txByte}, 32'h5A);
    @(negedge clk);
    chk("R9 start one cycle", {31'b0, txStart}, 0);
    xfer(1'b1, 5'hC, 32'h77, 4'hE);
    chk("R9 no start without lane 0", {31'b0, startSeen}, 0);
    txBusy = 1'b1;
    xfer(1'b1, 5'hC, 32'h66, 4'hF);
    chk("R9 busy ignored", {31'b0, startSeen}, 0);
    chk("R9 byte held", {24'b0, txByte}, 32'h5A);
    xfer(1'b0, 5'h0, 0, 4'hF);
    chk("R5 busy bit", rdData, 32'h2);
    txBusy = 1'b0;
    xfer(1'b0, 5'hC, 0, 4'hF);
    chk("R11 tx reads zero", rdData, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule